// File: doc/BRIEF.md
# Prescaler Tap Square-Wave Output

This block drives a single output pin with a square wave taken from a free-running prescaler. Two prescaler chains count independently: one on the fast gear-clock enable and one on the slow low-frequency clock enable. A small control register picks the chain and one of four taps. The wave toggles on each rising edge of the chosen tap bit, so the duty cycle is 50%. The pin rests high whenever the output is disabled.

Software writes the control register through a single-cycle write strobe. The register has three fields: an enable bit, a source bit and a 2-bit tap code. A level input reports that the system is running from the slow clock. While it is high, the slow-chain mapping applies whatever the source bit holds. A one-cycle pulse on the low-power entry input clears the enable bit in hardware. The chains never stop, so the first half-period after an enable can be shorter than the nominal one.

Top module: `divtap_out`

## Requirements
- R1: After synchronous reset `sq_out` is 1 and the enable bit is 0, so the pin stays high until a write sets the enable bit.
- R2: When the enable bit is 0, `sq_out` is 1 from the second rising clock edge after the write that cleared it.
- R3: With the fast source, code 0 gives a period of 512 fast ticks, code 1 gives 4096, code 2 gives 2048 and code 3 gives 1024. The pin toggles every half of that period.
- R4: With the slow source (`wr_src_slow`=1), code 1 gives a period of 32 slow ticks, code 2 gives 16 and code 3 gives 8.
- R5: While `slow_mode`=1 the slow-source mapping of R4 applies even if the source bit is 0.
- R6: Code 0 with the slow mapping is reserved: `sq_out` stays 1 while enabled.
- R7: A `lp_enter` pulse clears the enable bit at the next edge and overrides a write in the same cycle. `sq_out` is then 1 one edge later.
- R8: Both prescaler chains keep counting while the output is disabled, so the first interval after an enable is at most one nominal half-period.
- R9: While enabled, `sq_out` changes only on a rising edge of the selected tap. Successive high and low intervals are equal, which gives a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | One-cycle enable, one per gear-clock period |
| slow_tick | input | 1 | One-cycle enable, one per low-frequency clock period |
| slow_mode | input | 1 | High while the system runs from the slow clock |
| lp_enter | input | 1 | Pulse on entry to a stop or idle low-power mode |
| wr_en | input | 1 | Control register write strobe |
| wr_enable | input | 1 | Enable bit value to write |
| wr_src_slow | input | 1 | Source bit to write: 1 selects the slow chain |
| wr_sel | input | 2 | Tap code to write |
| sq_out | output | 1 | Registered square-wave output, high when idle |

## Verification
A write is captured at the edge where `wr_en` is high. `sq_out` reacts one edge later, so a forced-high result is checked at the falling edge after the second rising edge. A `lp_enter` pulse follows the same two-edge path. Periods are measured by counting falling edges between successive changes of `sq_out`. The first interval after an enable is only bounded, because the prescaler phase is arbitrary. The two intervals that follow must each equal exactly half the nominal period in clock cycles: one cycle per fast tick, or four cycles per slow tick as the bench drives it.

// File: rtl/divtap_pkg.sv
package divtap_pkg;
  typedef struct packed {
    logic       en;
    logic       src_slow;
    logic [1:0] sel;
  } divtap_cfg_t;
endpackage

// File: rtl/divtap_prescaler.sv
module divtap_prescaler #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] rise
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    if (i == 0) begin : g_lsb
      assign rise[i] = tick & ~cnt[0];
    end else begin : g_upper
      assign rise[i] = tick & ~cnt[i] & (&cnt[i-1:0]);
    end
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rise));
endmodule

// File: rtl/divtap_ctrl.sv
module divtap_ctrl
  import divtap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  divtap_cfg_t wr_cfg,
  input  logic        lp_enter,
  output divtap_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (wr_en) cfg_q <= wr_cfg;
      if (lp_enter) cfg_q.en <= 1'b0;
    end
  end

  // R7
  lp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    lp_enter |=> !cfg_q.en);
endmodule

// File: rtl/divtap_outgen.sv
module divtap_outgen
  import divtap_pkg::*;
#(
  parameter int FW = 11,
  parameter int SW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  divtap_cfg_t cfg,
  input  logic        slow_mode,
  input  logic [FW-1:0] fast_rise,
  input  logic [SW-1:0] slow_rise,
  output logic        q
);
  localparam int F_SEL0 = FW - 4;
  localparam int F_SEL1 = FW - 1;
  localparam int F_SEL2 = FW - 2;
  localparam int F_SEL3 = FW - 3;
  localparam int S_SEL1 = SW - 1;
  localparam int S_SEL2 = SW - 2;
  localparam int S_SEL3 = SW - 3;

  logic use_slow;
  logic sel_rise;
  logic reserved;

  always_comb begin
    use_slow = cfg.src_slow | slow_mode;
    reserved = 1'b0;
    sel_rise = 1'b0;
    if (use_slow) begin
      unique case (cfg.sel)
        2'd0: reserved = 1'b1;
        2'd1: sel_rise = slow_rise[S_SEL1];
        2'd2: sel_rise = slow_rise[S_SEL2];
        default: sel_rise = slow_rise[S_SEL3];
      endcase
    end else begin
      unique case (cfg.sel)
        2'd0: sel_rise = fast_rise[F_SEL0];
        2'd1: sel_rise = fast_rise[F_SEL1];
        2'd2: sel_rise = fast_rise[F_SEL2];
        default: sel_rise = fast_rise[F_SEL3];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b1;
    else if (!cfg.en || reserved) q <= 1'b1;
    else if (sel_rise) q <= ~q;
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.en) |-> q);
  // R6
  reserved_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.en) && $past(reserved) |-> q);
  // R9
  toggle_on_tap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.en) && !$past(reserved) && !$past(sel_rise) |-> $stable(q));
endmodule

// File: rtl/divtap_out.sv
module divtap_out
  import divtap_pkg::*;
#(
  parameter int FAST_W = 11,
  parameter int SLOW_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic       slow_mode,
  input  logic       lp_enter,
  input  logic       wr_en,
  input  logic       wr_enable,
  input  logic       wr_src_slow,
  input  logic [1:0] wr_sel,
  output logic       sq_out
);
  divtap_cfg_t       wr_cfg;
  divtap_cfg_t       cfg_q;
  logic [FAST_W-1:0] fast_rise;
  logic [SLOW_W-1:0] slow_rise;

  assign wr_cfg = '{en: wr_enable, src_slow: wr_src_slow, sel: wr_sel};

  divtap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cfg(wr_cfg),
    .lp_enter(lp_enter), .cfg_q(cfg_q)
  );

  divtap_prescaler #(.W(FAST_W)) u_fast (
    .clk(clk), .rst(rst), .tick(fast_tick), .rise(fast_rise)
  );

  divtap_prescaler #(.W(SLOW_W)) u_slow (
    .clk(clk), .rst(rst), .tick(slow_tick), .rise(slow_rise)
  );

  divtap_outgen #(.FW(FAST_W), .SW(SLOW_W)) u_out (
    .clk(clk), .rst(rst), .cfg(cfg_q), .slow_mode(slow_mode),
    .fast_rise(fast_rise), .slow_rise(slow_rise), .q(sq_out)
  );
endmodule

// File: tb/divtap_out_bench.sv
module divtap_out_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_DIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_tick = 1'b1;
  logic slow_tick = 1'b0;
  logic slow_mode = 1'b0;
  logic lp_enter = 1'b0;
  logic wr_en = 1'b0;
  logic wr_enable = 1'b0;
  logic wr_src_slow = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic sq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divtap_out u_divtap_out (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .slow_mode(slow_mode), .lp_enter(lp_enter), .wr_en(wr_en),
    .wr_enable(wr_enable), .wr_src_slow(wr_src_slow), .wr_sel(wr_sel),
    .sq_out(sq_out)
  );

  initial begin : slow_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % SLOW_DIV;
      slow_tick = (k == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit en, input bit src, input logic [1:0] sel);
    @(negedge clk);
    wr_en = 1'b1; wr_enable = en; wr_src_slow = src; wr_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_change(input int limit, output int n);
    logic prev;
    prev = sq_out;
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (sq_out !== prev) return;
    end
    n = -1;
  endtask

  task automatic hold_high(input int cycles, input string req);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sq_out !== 1'b1) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  task automatic measure(input string req, input int half);
    int first, a, b;
    wait_change(4 * half + 64, first);
    check(first >= 1 && first <= half, {req, "/R8 first"}, first, half);
    wait_change(4 * half + 64, a);
    check(a == half, {req, " half-period"}, a, half);
    wait_change(4 * half + 64, b);
    check(b == a, {req, "/R9 duty"}, b, a);
  endtask

  task automatic t_reset;
    check(sq_out === 1'b1, "R1 reset level", int'(sq_out), 1);
    hold_high(700, "R1 stays high without write");
  endtask

  task automatic t_fast;
    int halves[4] = '{256, 2048, 1024, 512};
    for (int s = 0; s < 4; s++) begin
      write_cfg(1'b1, 1'b0, 2'(s));
      measure("R3", halves[s]);
    end
  endtask

  task automatic t_disable;
    write_cfg(1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check(sq_out === 1'b1, "R2 forced high", int'(sq_out), 1);
    hold_high(600, "R2 held high");
  endtask

  task automatic t_slow;
    int halves[4] = '{0, 64, 32, 16};
    for (int s = 1; s < 4; s++) begin
      write_cfg(1'b1, 1'b1, 2'(s));
      measure("R4", halves[s]);
    end
  endtask

  task automatic t_reserved;
    write_cfg(1'b1, 1'b1, 2'd0);
    @(negedge clk);
    hold_high(1000, "R6 reserved code");
  endtask

  task automatic t_slow_mode;
    @(negedge clk);
    slow_mode = 1'b1;
    write_cfg(1'b1, 1'b0, 2'd1);
    measure("R5", 64);
    write_cfg(1'b1, 1'b0, 2'd0);
    @(negedge clk);
    hold_high(300, "R5 reserved under slow mode");
    @(negedge clk);
    slow_mode = 1'b0;
  endtask

  task automatic t_low_power;
    int n;
    write_cfg(1'b1, 1'b0, 2'd0);
    wait_change(600, n);
    check(sq_out === 1'b0, "R7 low before entry", int'(sq_out), 0);
    @(negedge clk);
    lp_enter = 1'b1;
    @(negedge clk);
    lp_enter = 1'b0;
    @(negedge clk);
    check(sq_out === 1'b1, "R7 high after entry", int'(sq_out), 1);
    hold_high(600, "R7 enable cleared");
    @(negedge clk);
    wr_en = 1'b1; wr_enable = 1'b1; wr_src_slow = 1'b0; wr_sel = 2'd0;
    lp_enter = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lp_enter = 1'b0;
    hold_high(600, "R7 overrides write");
  endtask

  task automatic t_truncate;
    write_cfg(1'b0, 1'b0, 2'd0);
    repeat (77) @(negedge clk);
    write_cfg(1'b1, 1'b0, 2'd0);
    measure("R8", 256);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fast();
    t_disable();
    t_slow();
    t_reserved();
    t_slow_mode();
    t_low_power();
    t_truncate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule